// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static RAM Model

This block is a synthesizable functional stand-in for a 16-bit asynchronous static RAM. It has active-low select, write and output-enable controls and two active-low byte-lane enables. The control pins are decoded into one of five modes: deselected, no lane chosen, outputs off, read and write. In read mode only the chosen lanes are driven. In write mode only the chosen lanes are stored. The bidirectional data bus is split into an input bus, an output bus and one drive-enable bit per byte lane. A pad ring or a testbench can join these into a tri-state bus.

A free-running sampling clock watches the write window, which is open while select and write enable are both low. Address, data and lane enables are captured on every edge while the window is open. The last capture is committed at the first edge that sees the window closed, whichever of the two controls rose first. Reads are combinational from the stored array. Storage depth is a parameter, and the address port may be wider than the storage, in which case the upper address bits alias.

Top module: `sram16_lane_model`

## Requirements
- R1: While `ce_n` is 1, `dq_oe` is 2'b00 and `dq_out` is zero, whatever the other pins do.
- R2: While `ce_n` is 0 and both `lb_n` and `ub_n` are 1, `dq_oe` is 2'b00 and `dq_out` is zero.
- R3: While `ce_n` is 0, `we_n` is 1 and `oe_n` is 1, `dq_oe` is 2'b00 and `dq_out` is zero.
- R4: While `ce_n`=0, `we_n`=1 and `oe_n`=0, `dq_oe[0]` equals the inverse of `lb_n` and `dq_oe[1]` equals the inverse of `ub_n`, in the same cycle with no clock involved. A driven lane shows the stored byte of the addressed word: bits 7:0 for the lower lane and bits 15:8 for the upper lane. An undriven lane reads zero.
- R5: The write window is the time during which `ce_n` and `we_n` are both 0. On the first clock edge at which the window is seen closed, the design stores the lanes whose enable was 0 at the last edge inside the window. It uses the address and `dq_in` sampled at that same edge. Other lanes keep their value, and `oe_n` has no effect on the write. The new data is readable right after that edge, whether `we_n` or `ce_n` closed the window.
- R6: While the window is open, `dq_oe` is 2'b00. Once `we_n` returns to 1 with a read condition present, the outputs are driven again in the same cycle.
- R7: A window whose last in-window sample had both lane enables at 1 changes no stored data.
- R8: Only the low `IDX_W` address bits select a word. With the defaults (9-bit address, 256 words), address 256+n and address n name the same word.
- R9: After reset every word reads as 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the write window |
| rst_n | input | 1 | Active-low reset; clears the array and the capture state |
| ce_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| lb_n | input | 1 | Active-low enable for data bits 7:0 |
| ub_n | input | 1 | Active-low enable for data bits 15:8 |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Write data from the bus |
| dq_out | output | 16 | Read data toward the bus; zero on an undriven lane |
| dq_oe | output | 2 | Per-lane drive enable: bit 0 for bits 7:0, bit 1 for bits 15:8 |

## Verification
Lane enables and read data depend only on the pins and the stored array, so they are due in the cycle in which the pins change. Stored data changes only at the first edge at which the window is seen closed, and it is visible from that edge on. The bench drives every pin one time unit after a rising edge and updates its behavioural model at each rising edge. It compares both outputs against the model at the falling edge, so each result is sampled half a period after it is due and never at an edge. Write sequences close the window by raising either control, and some change the data within the window, so the end-of-window sampling is checked.

// File: rtl/sram16_pkg.sv
package sram16_pkg;

    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;

    typedef enum logic [2:0] {
        MD_DESEL  = 3'd0,
        MD_NOLANE = 3'd1,
        MD_OUTOFF = 3'd2,
        MD_READ   = 3'd3,
        MD_WRITE  = 3'd4
    } mode_e;

endpackage

// File: rtl/sram16_mode_decode.sv
module sram16_mode_decode
    import sram16_pkg::*;
(
    input  logic             ce_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic             lb_n,
    input  logic             ub_n,
    output mode_e            mode,
    output logic [LANES-1:0] lane_sel,
    output logic             win_open
);

    always_comb begin
        lane_sel = {~ub_n, ~lb_n};
        win_open = ~ce_n & ~we_n;
        if (ce_n) begin
            mode = MD_DESEL;
        end else if (lb_n && ub_n) begin
            mode = MD_NOLANE;
        end else if (!we_n) begin
            mode = MD_WRITE;
        end else if (oe_n) begin
            mode = MD_OUTOFF;
        end else begin
            mode = MD_READ;
        end
    end

endmodule

// File: rtl/sram16_write_capture.sv
module sram16_write_capture
    import sram16_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_open,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] data,
    input  logic [LANES-1:0]  lane_sel,
    output logic              commit,
    output logic [IDX_W-1:0]  cap_idx,
    output logic [DATA_W-1:0] cap_data,
    output logic [LANES-1:0]  cap_lanes
);

    typedef struct packed {
        logic              win;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  lanes;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.win = win_open;
        if (win_open) begin
            st_d.idx   = idx;
            st_d.data  = data;
            st_d.lanes = lane_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit    = st_q.win & ~win_open;
    assign cap_idx   = st_q.idx;
    assign cap_data  = st_q.data;
    assign cap_lanes = st_q.lanes;

endmodule

// File: rtl/sram16_lane_array.sv
module sram16_lane_array
    import sram16_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << IDX_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) begin
                    mem_q[i] <= '0;
                end
            end else if (wr_en && wr_lanes[g]) begin
                mem_q[wr_idx] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = mem_q[rd_idx];
    end

endmodule

// File: rtl/sram16_lane_model.sv
module sram16_lane_model
    import sram16_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              lb_n,
    input  logic              ub_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic [LANES-1:0]  dq_oe
);

    mode_e             mode;
    logic [LANES-1:0]  lane_sel;
    logic              win_open;
    logic              commit;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  cap_idx;
    logic [DATA_W-1:0] cap_data;
    logic [LANES-1:0]  cap_lanes;
    logic [DATA_W-1:0] rd_data;

    assign idx = addr[IDX_W-1:0];

    if (ADDR_W > IDX_W) begin : g_alias
        logic addr_hi_unused;
        assign addr_hi_unused = ^addr[ADDR_W-1:IDX_W];
    end

    sram16_mode_decode u_dec (
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .lb_n     (lb_n),
        .ub_n     (ub_n),
        .mode     (mode),
        .lane_sel (lane_sel),
        .win_open (win_open)
    );

    sram16_write_capture #(.IDX_W(IDX_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_open  (win_open),
        .idx       (idx),
        .data      (dq_in),
        .lane_sel  (lane_sel),
        .commit    (commit),
        .cap_idx   (cap_idx),
        .cap_data  (cap_data),
        .cap_lanes (cap_lanes)
    );

    sram16_lane_array #(.IDX_W(IDX_W)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (commit),
        .wr_idx   (cap_idx),
        .wr_data  (cap_data),
        .wr_lanes (cap_lanes),
        .rd_idx   (idx),
        .rd_data  (rd_data)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_out
        assign dq_oe[g] = (mode == MD_READ) && lane_sel[g];
        assign dq_out[g*LANE_W +: LANE_W] = dq_oe[g] ? rd_data[g*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/sram16_lane_checker.sv
module sram16_lane_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        ce_n,
    input logic        we_n,
    input logic        oe_n,
    input logic        lb_n,
    input logic        ub_n,
    input logic [15:0] dq_out,
    input logic [1:0]  dq_oe
);

    AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (dq_oe == 2'b00 && dq_out == 16'h0)); // R1

    AST_NOLANE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_n && ub_n) |-> (dq_oe == 2'b00)); // R2

    AST_OUTOFF_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && we_n && oe_n) |-> (dq_oe == 2'b00)); // R3

    AST_READ_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && we_n && !oe_n) |-> (dq_oe == {~ub_n, ~lb_n})); // R4

    AST_LO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe[0] |-> (dq_out[7:0] == 8'h0)); // R4

    AST_HI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe[1] |-> (dq_out[15:8] == 8'h0)); // R4

    AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |-> (dq_oe == 2'b00)); // R6

endmodule

bind sram16_lane_model sram16_lane_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .we_n   (we_n),
    .oe_n   (oe_n),
    .lb_n   (lb_n),
    .ub_n   (ub_n),
    .dq_out (dq_out),
    .dq_oe  (dq_oe)
);

// File: tb/sim_sram16_lane_model.sv
module sim_sram16_lane_model;

    localparam int CLK_P = 10;
    localparam int AW    = 9;
    localparam int WORDS = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   dq_in = '0;
    logic [15:0]   dq_out;
    logic [1:0]    dq_oe;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string phase = "R9 reset";

    int    ref_mem [WORDS];
    bit    r_win = 1'b0;
    int    r_idx = 0;
    int    r_data = 0;
    bit    r_lo = 1'b0, r_hi = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    sram16_lane_model #(.ADDR_W(AW), .IDX_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // Behavioural reference: window capture and commit (R5, R7), reset (R9)
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (ref_mem[i]) ref_mem[i] = 0;
            r_win = 1'b0;
        end else begin
            bit w;
            w = !ce_n && !we_n;
            if (r_win && !w) begin
                if (r_lo) ref_mem[r_idx] = (ref_mem[r_idx] & 32'hFF00) | (r_data & 32'h00FF);
                if (r_hi) ref_mem[r_idx] = (ref_mem[r_idx] & 32'h00FF) | (r_data & 32'hFF00);
            end
            if (w) begin
                r_idx  = int'(addr) % WORDS;
                r_data = int'(dq_in);
                r_lo   = !lb_n;
                r_hi   = !ub_n;
            end
            r_win = w;
        end
    end

    // Compare on every falling edge (R1, R2, R3, R4, R6, R8)
    always @(negedge clk) begin
        if (!done) begin
            logic [1:0]  e_oe;
            logic [15:0] e_out;
            logic [15:0] word;
            word  = 16'(ref_mem[int'(addr) % WORDS]);
            e_oe  = 2'b00;
            if (!ce_n && we_n && !oe_n) e_oe = {!ub_n, !lb_n};
            e_out = {e_oe[1] ? word[15:8] : 8'h00, e_oe[0] ? word[7:0] : 8'h00};
            n_cmp++;
            if (dq_oe !== e_oe || dq_out !== e_out) begin
                n_bad++;
                $display("FAIL %s: pins ce%b we%b oe%b lb%b ub%b addr %0d actual oe=%b out=%h expected oe=%b out=%h",
                         phase, ce_n, we_n, oe_n, lb_n, ub_n, addr, dq_oe, dq_out, e_oe, e_out);
            end
        end
    end

    task automatic cyc(input logic c, input logic w, input logic o, input logic l,
                       input logic u, input int a, input logic [15:0] d);
        @(posedge clk);
        #1;
        ce_n = c; we_n = w; oe_n = o; lb_n = l; ub_n = u;
        addr = AW'(a); dq_in = d;
    endtask

    task automatic idle();
        cyc(1, 1, 1, 1, 1, 0, 16'h0);
    endtask

    // Window closed by write enable; data changes inside the window
    task automatic wr_we(input int a, input logic [15:0] d, input logic l, input logic u, input logic o);
        cyc(0, 0, o, l, u, a, ~d);
        cyc(0, 0, o, l, u, a, d);
        cyc(0, 1, 0, 0, 0, a, 16'h0);
        idle();
    endtask

    // Window closed by chip select
    task automatic wr_ce(input int a, input logic [15:0] d, input logic l, input logic u);
        cyc(0, 0, 0, l, u, a, d);
        cyc(0, 0, 0, l, u, a, d);
        cyc(1, 0, 0, l, u, a, 16'h0);
        idle();
    endtask

    task automatic rd(input int a, input logic l, input logic u);
        cyc(0, 1, 0, l, u, a, 16'h0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog in phase %s: actual hung, expected finish", phase);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        phase = "R9 reset contents";
        for (int a = 0; a < WORDS; a++) rd(a, 0, 0);

        phase = "R1 deselect";
        cyc(1, 1, 0, 0, 0, 3, 16'h0);
        cyc(1, 0, 0, 0, 0, 3, 16'hAAAA);
        cyc(1, 1, 0, 1, 0, 3, 16'h0);
        idle();

        phase = "R5 word fill";
        for (int a = 0; a < WORDS; a++) wr_we(a, 16'(a * 16'h0101 ^ 16'h5A3C), 0, 0, a[0]);

        phase = "R4 word/byte reads";
        for (int a = 0; a < WORDS; a++) begin
            rd(a, 0, 0);
            rd(a, 0, 1);
            rd(a, 1, 0);
        end

        phase = "R2 no lane";
        cyc(0, 1, 0, 1, 1, 7, 16'h0);
        cyc(0, 0, 0, 1, 1, 7, 16'h0);
        phase = "R3 outputs off";
        cyc(0, 1, 1, 0, 0, 7, 16'h0);
        cyc(0, 1, 1, 0, 1, 7, 16'h0);
        idle();

        phase = "R7 empty window";
        wr_we(10, 16'hDEAD, 1, 1, 0);
        wr_ce(11, 16'hBEEF, 1, 1);
        rd(10, 0, 0);
        rd(11, 0, 0);

        phase = "R5 mixed byte writes";
        for (int a = 0; a < WORDS; a += 3) begin
            if (a % 2 == 0) wr_we(a, 16'(16'hC300 + a), 0, 1, 1);
            else            wr_ce(a, 16'(16'h00A5 + (a << 8)), 1, 0);
        end
        wr_we(20, 16'h1200, 1, 0, 0);
        wr_ce(20, 16'h0034, 0, 1);

        phase = "R6 read after write enable rises";
        cyc(0, 0, 0, 0, 0, 30, 16'h7E81);
        cyc(0, 1, 0, 0, 0, 30, 16'h0);
        cyc(0, 1, 0, 0, 0, 30, 16'h0);
        idle();

        phase = "R8 address alias";
        wr_we(256 + 5, 16'h9C63, 0, 0, 1);
        rd(5, 0, 0);
        rd(256 + 5, 0, 0);
        rd(256 + 200, 0, 0);

        phase = "R5 word readback";
        for (int a = 0; a < WORDS; a++) rd(a, 0, 0);
        idle();

        @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule